// File: doc/BRIEF.md
# FIFO Interrupt Status Controller

This block collects the FIFO-related events of a serial flash controller into a status register. It raises one interrupt line for the events that software has chosen to enable. Six sources are tracked. Four come from FIFO occupancy: TX below its threshold, TX full, RX at or above its threshold, and RX full. Two are event pulses: RX overflow and TX underflow. The block compares the TX and RX occupancy counts it receives against two programmable threshold registers. It latches the results and combines them with an interrupt mask.

Software changes the mask in two ways. Writing ones to a set register turns mask bits on. Writing ones to a separate clear register turns them off. The mask itself can be read but not written, so no read-modify-write is needed. The status register is cleared by writing ones to it. A level source whose condition still holds sets its bit again one cycle after a clear. A bit set by an event pulse stays set until software clears it. The FIFOs, the serial shifter and the bus bridge sit outside this block. A plain single-cycle register port with combinational read data connects it to the bridge.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Register addresses are: 0 status, 1 mask-set, 2 mask-clear, 3 mask (read-only), 4 TX threshold, 5 RX threshold. In the status, mask-set, mask-clear and mask registers, bit 0 is RX overflow, bit 2 TX not-full, bit 3 TX full, bit 4 RX not-empty, bit 5 RX full and bit 6 TX underflow. Bits 1 and 7 and addresses 6 and 7 read as zero.
- R2: Writing to address 1 sets every mask bit that is written as one and leaves the other mask bits unchanged. Address 1 reads as zero.
- R3: Writing to address 2 clears every mask bit that is written as one and leaves the other mask bits unchanged. Address 2 reads as zero.
- R4: A write to address 3 leaves the mask unchanged.
- R5: Writing a one to a status bit position clears that bit at the next clock. Writing zero to a status bit position has no effect on that bit.
- R6: Status bit 2 is set one clock after a cycle in which the TX count is below the TX threshold register.
- R7: Status bit 4 is set after a cycle in which the RX count is at or above the RX threshold. Bits 3 and 5 are set after a cycle in which the TX count or the RX count, respectively, equals DEPTH.
- R8: During reset the status register and the mask read zero, the TX threshold reads 1 and the RX threshold reads 32.
- R9: A level status bit (bits 2 to 5) is zero for the cycle after it is cleared, even if its condition holds. The bit is set again at the following clock if the condition still holds. Once set, it stays set when the condition goes away.
- R10: The overflow bit (0) and the underflow bit (6) are sticky. An event arriving in the same cycle as a clear of that bit leaves the bit set.
- R11: irq is high exactly when some status bit and the same mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| tx_level | input | CNT_W | TX FIFO occupancy |
| rx_level | input | CNT_W | RX FIFO occupancy |
| rx_ovf_evt | input | 1 | One-cycle RX overflow pulse |
| tx_udf_evt | input | 1 | One-cycle TX underflow pulse |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every clock:
- the effect of a write to the mask-set, mask-clear and read-only mask addresses on the mask;
- that the overflow bit persists unless it is cleared;
- that TX not-full follows the threshold comparison;
- that a clear of a level bit wins for one cycle;
- that irq never rises without an enabled, pending bit.

Other behaviours can only be shown by the bench scenarios, which compare each read against a cycle-level reference model. These are the reset values of the thresholds, the re-setting of a level bit after a clear, an event arriving together with its clear, and the effect of reprogramming the thresholds on the not-full and not-empty sources.

// File: rtl/fic_pkg.sv
// Shared constants for the FIFO interrupt status controller: status bit
// positions, register addresses and the per-bit source kind.
package fic_pkg;
    localparam int STAT_W    = 7;
    localparam int B_RX_OVF  = 0;
    localparam int B_TX_NF   = 2;
    localparam int B_TX_FULL = 3;
    localparam int B_RX_NE   = 4;
    localparam int B_RX_FULL = 5;
    localparam int B_TX_UDF  = 6;
    localparam logic [STAT_W-1:0] VALID_BITS = 7'b111_1101;

    typedef enum logic [2:0] {
        A_STATUS = 3'd0,
        A_ENSET  = 3'd1,
        A_ENCLR  = 3'd2,
        A_MASK   = 3'd3,
        A_TXTH   = 3'd4,
        A_RXTH   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {K_NONE, K_EVENT, K_LEVEL} bit_kind_e;

    // Kind of source feeding each status bit position.
    function automatic bit_kind_e kind_of(input int idx);
        case (idx)
            B_RX_OVF, B_TX_UDF:                     return K_EVENT;
            B_TX_NF, B_TX_FULL, B_RX_NE, B_RX_FULL: return K_LEVEL;
            default:                                return K_NONE;
        endcase
    endfunction
endpackage

// File: rtl/fic_src_detect.sv
// Source detection: turns FIFO occupancy, threshold registers and event
// pulses into one raw request per status bit position. Purely combinational.
// Assumes the counts never exceed DEPTH.
module fic_src_detect
    import fic_pkg::*;
#(
    parameter int DEPTH = 63,
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_thr,
    input  logic [CNT_W-1:0]  rx_thr,
    input  logic              rx_ovf_evt,
    input  logic              tx_udf_evt,
    output logic [STAT_W-1:0] src
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Compare occupancy against thresholds and the full level.
    always_comb begin
        src             = '0;
        src[B_RX_OVF]   = rx_ovf_evt;
        src[B_TX_NF]    = (tx_level < tx_thr);
        src[B_TX_FULL]  = (tx_level == FULL_CNT);
        src[B_RX_NE]    = (rx_level >= rx_thr);
        src[B_RX_FULL]  = (rx_level == FULL_CNT);
        src[B_TX_UDF]   = tx_udf_evt;
    end
endmodule

// File: rtl/fic_status_reg.sv
// Status register with write-one-to-clear. Event bits give priority to a
// new event over a clear. Level bits give priority to the clear for one
// cycle. All bits are sticky. Unused positions are tied to zero.
module fic_status_reg
    import fic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] src,
    input  logic [STAT_W-1:0] clr,
    output logic [STAT_W-1:0] status
);
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (kind_of(i) == K_EVENT) begin : g_evt
            logic q;
            // Sticky event bit: a new event beats a simultaneous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= (q & ~clr[i]) | src[i];
            end
            assign status[i] = q;
        end else if (kind_of(i) == K_LEVEL) begin : g_lvl
            logic q;
            // Latched level bit: a clear wins for one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)      q <= 1'b0;
                else if (clr[i]) q <= 1'b0;
                else             q <= q | src[i];
            end
            assign status[i] = q;
        end else begin : g_none
            assign status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/fic_mask_reg.sv
// Interrupt mask, changed only through separate set and clear strobes.
// Assumes set and clear never arrive in the same cycle.
module fic_mask_reg
    import fic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_bits,
    input  logic [STAT_W-1:0] clr_bits,
    output logic [STAT_W-1:0] mask
);
    // Apply set then clear; only valid positions can ever be set.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask | (set_bits & VALID_BITS)) & ~clr_bits;
    end
endmodule

// File: rtl/fifo_irq_ctrl.sv
// FIFO interrupt status controller top. Decodes the register port, holds
// the two threshold registers, drives the read mux and forms irq.
// Assumes a single-cycle write strobe and DATA_W >= max(8, CNT_W).
module fifo_irq_ctrl
    import fic_pkg::*;
#(
    parameter int DEPTH     = 63,
    parameter int DATA_W    = 8,
    parameter int TX_TH_RST = 1,
    parameter int RX_TH_RST = 32,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic              rx_ovf_evt,
    input  logic              tx_udf_evt,
    output logic              irq
);
    logic [STAT_W-1:0] wbits;
    logic [STAT_W-1:0] src, stat_clr, mask_set, mask_clr;
    logic [STAT_W-1:0] status_q, mask_q;
    logic [CNT_W-1:0]  tx_thr_q, rx_thr_q;

    assign wbits = reg_wdata[STAT_W-1:0];

    // Write decode into per-register bit strobes.
    always_comb begin
        stat_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        if (reg_wr) begin
            case (reg_addr)
                A_STATUS: stat_clr = wbits;
                A_ENSET:  mask_set = wbits;
                A_ENCLR:  mask_clr = wbits;
                default:  ;
            endcase
        end
    end

    // Threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= CNT_W'(TX_TH_RST);
            rx_thr_q <= CNT_W'(RX_TH_RST);
        end else if (reg_wr && reg_addr == A_TXTH) begin
            tx_thr_q <= reg_wdata[CNT_W-1:0];
        end else if (reg_wr && reg_addr == A_RXTH) begin
            rx_thr_q <= reg_wdata[CNT_W-1:0];
        end
    end

    fic_src_detect #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_src (
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .tx_thr     (tx_thr_q),
        .rx_thr     (rx_thr_q),
        .rx_ovf_evt (rx_ovf_evt),
        .tx_udf_evt (tx_udf_evt),
        .src        (src)
    );

    fic_status_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src),
        .clr    (stat_clr),
        .status (status_q)
    );

    fic_mask_reg u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (mask_set),
        .clr_bits (mask_clr),
        .mask     (mask_q)
    );

    // Read mux; write-only and unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATUS: reg_rdata[STAT_W-1:0] = status_q;
            A_MASK:   reg_rdata[STAT_W-1:0] = mask_q;
            A_TXTH:   reg_rdata[CNT_W-1:0]  = tx_thr_q;
            A_RXTH:   reg_rdata[CNT_W-1:0]  = rx_thr_q;
            default:  ;
        endcase
    end

    // Interrupt: any pending and enabled source.
    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/fic_irq_checker.sv
// Assertion checker bound to fifo_irq_ctrl; observes ports and the
// status, mask and threshold state.
module fic_irq_checker
    import fic_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [STAT_W-1:0] wbits,
    input logic [STAT_W-1:0] status,
    input logic [STAT_W-1:0] mask,
    input logic [CNT_W-1:0]  tx_level,
    input logic [CNT_W-1:0]  tx_thr,
    input logic              irq
);
    logic armed;
    // Marks that at least one clock has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    logic wr_stat;
    assign wr_stat = reg_wr && (reg_addr == A_STATUS);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENSET) |=> ((mask & $past(wbits & VALID_BITS)) == $past(wbits & VALID_BITS))); // R2
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENCLR) |=> ((mask & $past(wbits)) == '0)); // R3
    AST_MASK_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MASK) |=> (mask == $past(mask))); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(status[B_RX_OVF]) && !$past(wr_stat && wbits[B_RX_OVF])) |-> status[B_RX_OVF]); // R10
    AST_TXNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(tx_level < tx_thr) && !$past(wr_stat && wbits[B_TX_NF])) |-> status[B_TX_NF]); // R6
    AST_LEVEL_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wbits[B_TX_FULL]) |=> !status[B_TX_FULL]); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(status & mask))); // R11
endmodule

bind fifo_irq_ctrl fic_irq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wbits    (reg_wdata[fic_pkg::STAT_W-1:0]),
    .status   (status_q),
    .mask     (mask_q),
    .tx_level (tx_level),
    .tx_thr   (tx_thr_q),
    .irq      (irq)
);

// File: tb/tb_fifo_irq_ctrl.sv
module tb_fifo_irq_ctrl;
    localparam int DEPTH  = 63;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [CNT_W-1:0]  tx_level = '0;
    logic [CNT_W-1:0]  rx_level = '0;
    logic              rx_ovf_evt = 1'b0;
    logic              tx_udf_evt = 1'b0;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    fifo_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .tx_level, .rx_level, .rx_ovf_evt, .tx_udf_evt, .irq
    );

    // Reference model state.
    bit [6:0] m_stat, m_mask, m_clr, m_lvl;
    int       m_txth, m_rxth;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = '0; m_mask = '0; m_txth = 1; m_rxth = 32;
        end else begin
            m_clr = (reg_wr && reg_addr == 3'd0) ? reg_wdata[6:0] : 7'd0;
            m_lvl = '0;
            m_lvl[2] = (int'(tx_level) < m_txth);
            m_lvl[3] = (int'(tx_level) == DEPTH);
            m_lvl[4] = (int'(rx_level) >= m_rxth);
            m_lvl[5] = (int'(rx_level) == DEPTH);
            m_stat[0] = (m_stat[0] && !m_clr[0]) || rx_ovf_evt;
            m_stat[6] = (m_stat[6] && !m_clr[6]) || tx_udf_evt;
            for (int j = 2; j <= 5; j++)
                m_stat[j] = m_clr[j] ? 1'b0 : (m_stat[j] || m_lvl[j]);
            if (reg_wr && reg_addr == 3'd1) m_mask = m_mask | (reg_wdata[6:0] & 7'h7D);
            if (reg_wr && reg_addr == 3'd2) m_mask = m_mask & ~reg_wdata[6:0];
            if (reg_wr && reg_addr == 3'd4) m_txth = int'(reg_wdata[5:0]);
            if (reg_wr && reg_addr == 3'd5) m_rxth = int'(reg_wdata[5:0]);
        end
    end

    function automatic int model_read(input logic [2:0] a);
        case (a)
            3'd0:    return int'(m_stat);
            3'd3:    return int'(m_mask);
            3'd4:    return m_txth;
            3'd5:    return m_rxth;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R11: irq compared with the model every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done)
            check(irq == |(m_stat & m_mask), "R11 irq", int'(irq), int'(|(m_stat & m_mask)));
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 check(int'(reg_rdata) == model_read(a), req, int'(reg_rdata), model_read(a));
    endtask

    task automatic rd_exp(input logic [2:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 check(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset values read during reset.
        rd_exp(3'd0, 0, "R8 status in reset");
        rd_exp(3'd3, 0, "R8 mask in reset");
        rd_exp(3'd4, 1, "R8 tx threshold reset");
        rd_exp(3'd5, 32, "R8 rx threshold reset");
        check(irq == 1'b0, "R8 irq in reset", int'(irq), 0);
        @(negedge clk); rst_n = 1'b1;
        // R6: empty TX below threshold 1 sets bit 2 after one clock.
        rd_exp(3'd0, 8'h04, "R6 tx not-full after reset");
        // R2: enable all; unused bits never set; address reads zero.
        wr(3'd1, 8'hFF);
        rd_exp(3'd3, 8'h7D, "R2 mask set all");
        rd_exp(3'd1, 0, "R2 set reg reads zero");
        // R3: clear all but bit 2.
        wr(3'd2, 8'h79);
        rd_exp(3'd3, 8'h04, "R3 mask clear");
        rd_exp(3'd2, 0, "R3 clear reg reads zero");
        // R4: write to the mask address is ignored.
        wr(3'd3, 8'h00);
        rd_exp(3'd3, 8'h04, "R4 mask read-only");
        // R5: clear bit 2 with condition gone; zero write no effect.
        tx_level = 6'd5;
        wr(3'd0, 8'h04);
        rd_exp(3'd0, 0, "R5 w1c clears");
        tx_level = 6'd0;
        @(negedge clk);
        wr(3'd0, 8'h00);
        rd_exp(3'd0, 8'h04, "R5 zero write keeps bit");
        // R9: clear while condition holds: zero one cycle, then back.
        wr(3'd0, 8'h04);
        rd_exp(3'd0, 0, "R9 clear wins one cycle");
        rd_exp(3'd0, 8'h04, "R9 level re-sets");
        // R9: sticky after condition goes away.
        tx_level = 6'd9;
        repeat (3) @(negedge clk);
        rd_exp(3'd0, 8'h04, "R9 level bit sticky");
        // R6: threshold 4.
        wr(3'd4, 8'd4);
        rd_chk(3'd4, "R6 tx threshold write");
        tx_level = 6'd4;
        wr(3'd0, 8'h04);
        @(negedge clk);
        rd_exp(3'd0, 0, "R6 count equal threshold not set");
        tx_level = 6'd3;
        @(negedge clk);
        rd_exp(3'd0, 8'h04, "R6 count below threshold sets");
        // R7: full levels and rx threshold.
        tx_level = 6'd63; rx_level = 6'd63;
        @(negedge clk);
        rd_exp(3'd0, 8'h3C, "R7 full and rx not-empty");
        rx_level = 6'd10; tx_level = 6'd20;
        wr(3'd0, 8'h7F);
        @(negedge clk);
        rd_exp(3'd0, 0, "R7 rx below threshold");
        wr(3'd5, 8'd8);
        @(negedge clk);
        rd_exp(3'd0, 8'h10, "R7 rx threshold lowered");
        // R10: overflow event sticky.
        @(negedge clk); rx_ovf_evt = 1'b1;
        @(negedge clk); rx_ovf_evt = 1'b0;
        repeat (4) @(negedge clk);
        rd_exp(3'd0, 8'h11, "R10 overflow sticky");
        // R10: underflow arrives with its clear; bit 0 clears.
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h41; tx_udf_evt = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0; tx_udf_evt = 1'b0;
        rd_exp(3'd0, 8'h50, "R10 event beats clear");
        // R11: enable event bits, irq rises; disable all, irq drops.
        wr(3'd1, 8'h41);
        @(negedge clk);
        check(irq == 1'b1, "R11 irq enabled", int'(irq), 1);
        wr(3'd2, 8'h7F);
        @(negedge clk);
        check(irq == 1'b0, "R11 irq masked", int'(irq), 0);
        // R1: unmapped addresses read zero and writes there do nothing.
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        rd_exp(3'd6, 0, "R1 addr 6 reads zero");
        rd_exp(3'd7, 0, "R1 addr 7 reads zero");
        rd_chk(3'd3, "R1 mask after unmapped write");
        rd_chk(3'd0, "R1 status layout");
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule